// File: doc/BRIEF.md
# Return-to-One Single-Wire Serial Target

This block is the target end of a one-pin, open-drain, bidirectional command link to a host. The shared line idles high. Each bit starts with a falling edge, and the bit value is whatever level the line holds at a fixed sample point after that edge. The host first sends a command byte. Bit 7 of that byte selects the direction, and the lower seven bits select a register. On a write, the block collects one more byte and presents it to a register-file port with a single-cycle strobe. The strobe is given only if the surrounding logic reports the address as valid. On a read, the block waits a bounded turnaround time and then drives the addressed register's byte back on the same line, using the same framing.

A low level held far longer than any data bit is a break. A break drops whatever transfer is under way. After a short high recovery time, the block is ready for a fresh command.

The line input passes through a two-flop synchroniser. The pull-low output is meant for an open-drain pad. All timing is given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter.

Top module: `rto_target`

## Requirements
- R1: The value of each received bit is the synchronised line level 70 µs after the falling edge that starts the bit. Bytes are 8 bits and arrive least-significant bit first.
- R2: If bit 7 of the command is 1, the next received byte is presented on `reg_wdata_o`, with `reg_addr_o` equal to command bits 6:0. `reg_we_o` is high for exactly one cycle.
- R3: If `addr_valid_i` is low when the write byte completes, `reg_we_o` stays low and the register file is left untouched.
- R4: If bit 7 of the command is 0, the block sends back the 8 bits of `reg_rdata_i` for the addressed register, least-significant bit first. `reg_addr_o` stays stable while the reply is sent.
- R5: The first reply bit begins between 190 µs and 320 µs after the line goes high at the end of the command byte.
- R6: Each reply bit holds the line low for at least 32 µs. A 1 is sent by releasing the line at 40 µs. A 0 is sent by holding the line low until 120 µs. The interval from one reply bit start to the next is between 190 µs and 250 µs.
- R7: A low level lasting 160 µs or more after a falling edge is treated as a break. It discards any partial command or data byte, and no write strobe follows from that byte. Once the line has been high for 20 µs, a new command is accepted.
- R8: `line_pull_o` is asserted only while a reply is being sent. After reset, `line_pull_o` and `reg_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw level of the shared serial line |
| line_pull_o | output | 1 | 1 pulls the line low via open-drain pad |
| reg_addr_o | output | 7 | Register address from the command byte |
| reg_wdata_o | output | 8 | Byte received for a write |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Contents of the addressed register |
| addr_valid_i | input | 1 | The current address accepts writes |

## Verification
Writes and reads use asymmetric bytes such as A5 and 3C. A byte that is bit-reversed, or a data byte written to the wrong register, therefore reads back wrong. All-ones and all-zeros bytes test each reply encoding on its own, across a whole byte. A write to an address outside the valid range, followed by a read of that address, tells a suppressed strobe apart from a wrong one. Breaks placed partway through a command and partway through a data byte show that partial bytes are discarded and that the next complete command still decodes cleanly.

// File: rtl/rto_pkg.sv
package rto_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_DATA,
    ST_TURN,
    ST_TX,
    ST_BRK
  } rto_state_e;
endpackage

// File: rtl/rto_sync.sv
module rto_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rto_rx.sv
module rto_rx #(
  parameter int unsigned SMP_C = 140,
  parameter int unsigned BRK_C = 320
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line_i,
  output logic bit_vld_o,
  output logic bit_o,
  output logic brk_o
);
  localparam int unsigned CW = $clog2(BRK_C + 1);

  logic          prev_q, act_q;
  logic [CW-1:0] cnt_q;
  logic          fall;

  assign fall      = en_i & prev_q & ~line_i;
  assign bit_vld_o = act_q && (cnt_q == CW'(SMP_C));
  assign bit_o     = line_i;
  assign brk_o     = act_q && !line_i && (cnt_q == CW'(BRK_C));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= line_i;
      if (!en_i) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (fall) begin
        act_q <= 1'b1;
        cnt_q <= CW'(1);
      end else if (act_q) begin
        if (brk_o) act_q <= 1'b0;
        else if (line_i && cnt_q > CW'(SMP_C)) act_q <= 1'b0;  // bit done, line back high
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rto_tx.sv
module rto_tx #(
  parameter int unsigned DW      = 8,
  parameter int unsigned START_C = 80,
  parameter int unsigned ZERO_C  = 240,
  parameter int unsigned BIT_C   = 420
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic          pull_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(BIT_C);
  localparam int unsigned IW = $clog2(DW);

  logic          busy_q, done_q;
  logic [DW-1:0] sh_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = cnt_q == CW'(BIT_C - 1);
  assign pull_o = busy_q && ((cnt_q < CW'(START_C)) || (!sh_q[0] && cnt_q < CW'(ZERO_C)));
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        sh_q   <= data_i;
        idx_q  <= '0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          cnt_q <= '0;
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + 1'b1;
          if (idx_q == IW'(DW - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rto_target.sv
module rto_target #(
  parameter int unsigned CYC_PER_US = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned SMP_US     = 70,
  parameter int unsigned BRK_US     = 160,
  parameter int unsigned REC_US     = 20,
  parameter int unsigned TURN_US    = 200,
  parameter int unsigned START_US   = 40,
  parameter int unsigned ZERO_US    = 120,
  parameter int unsigned BIT_US     = 210
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  output logic          line_pull_o,
  output logic [DW-2:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic          addr_valid_i
);
  import rto_pkg::*;

  localparam int unsigned AW      = DW - 1;
  localparam int unsigned NBW     = $clog2(DW);
  localparam int unsigned SMP_C   = SMP_US * CYC_PER_US;
  localparam int unsigned BRK_C   = BRK_US * CYC_PER_US;
  localparam int unsigned REC_C   = REC_US * CYC_PER_US;
  localparam int unsigned TURN_C  = TURN_US * CYC_PER_US;
  localparam int unsigned START_C = START_US * CYC_PER_US;
  localparam int unsigned ZERO_C  = ZERO_US * CYC_PER_US;
  localparam int unsigned BIT_C   = BIT_US * CYC_PER_US;
  localparam int unsigned WC      = $clog2(TURN_C + REC_C + 1);

  rto_state_e     state_q;
  logic           line_s;
  logic           bit_vld, bit_val, brk;
  logic           tx_start_q, tx_done;
  logic [DW-1:0]  sh_q, sh_nxt;
  logic [NBW-1:0] nbit_q;
  logic [WC-1:0]  cnt_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           we_q;
  logic           byte_done;

  rto_sync #(.RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  rto_rx #(.SMP_C(SMP_C), .BRK_C(BRK_C)) i_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q != ST_TX),
    .line_i   (line_s),
    .bit_vld_o(bit_vld),
    .bit_o    (bit_val),
    .brk_o    (brk)
  );

  rto_tx #(.DW(DW), .START_C(START_C), .ZERO_C(ZERO_C), .BIT_C(BIT_C)) i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tx_start_q),
    .data_i (reg_rdata_i),
    .pull_o (line_pull_o),
    .done_o (tx_done)
  );

  // LSB arrives first: shift in at the top
  assign sh_nxt    = {bit_val, sh_q[DW-1:1]};
  assign byte_done = bit_vld && (nbit_q == NBW'(DW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CMD;
      sh_q       <= '0;
      nbit_q     <= '0;
      cnt_q      <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
      tx_start_q <= 1'b0;
    end else begin
      we_q       <= 1'b0;
      tx_start_q <= 1'b0;
      unique case (state_q)
        ST_CMD, ST_DATA: begin
          if (brk) begin
            state_q <= ST_BRK;
            nbit_q  <= '0;
            cnt_q   <= '0;
          end else if (bit_vld) begin
            sh_q   <= sh_nxt;
            nbit_q <= nbit_q + 1'b1;
            if (byte_done) begin
              nbit_q <= '0;
              cnt_q  <= '0;
              if (state_q == ST_CMD) begin
                addr_q  <= sh_nxt[AW-1:0];
                state_q <= sh_nxt[DW-1] ? ST_DATA : ST_TURN;
              end else begin
                wdata_q <= sh_nxt;
                we_q    <= addr_valid_i;
                state_q <= ST_CMD;
              end
            end
          end
        end
        ST_TURN: begin
          // turnaround counts from the line being high after the last command bit
          if (brk) begin
            state_q <= ST_BRK;
            cnt_q   <= '0;
          end else if (!line_s) begin
            cnt_q <= '0;
          end else if (cnt_q == WC'(TURN_C - 1)) begin
            cnt_q      <= '0;
            tx_start_q <= 1'b1;
            state_q    <= ST_TX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TX: begin
          if (tx_done) state_q <= ST_CMD;
        end
        ST_BRK: begin
          if (!line_s) begin
            cnt_q <= '0;
          end else if (cnt_q == WC'(REC_C - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_CMD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_CMD;
      endcase
    end
  end

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
endmodule

// File: rtl/rto_chk.sv
module rto_chk #(
  parameter int unsigned AW = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input rto_pkg::rto_state_e  state_i,
  input logic                 line_pull_i,
  input logic                 reg_we_i,
  input logic                 addr_valid_i,
  input logic [AW-1:0]        reg_addr_i,
  input logic                 brk_i
);
  import rto_pkg::*;

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !reg_we_i); // R2

  AST_WE_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> $past(state_i) == ST_DATA); // R2

  AST_WE_VALID_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> addr_valid_i); // R3

  AST_ADDR_STABLE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_TX && $past(state_i) == ST_TX) |-> $stable(reg_addr_i)); // R4

  AST_BRK_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && state_i != ST_TX) |=> state_i == ST_BRK); // R7

  AST_BRK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_BRK |-> (!reg_we_i && !line_pull_i)); // R7

  AST_PULL_IN_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_pull_i |-> state_i == ST_TX); // R8
endmodule

bind rto_target rto_chk #(.AW(AW)) i_rto_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state_q),
  .line_pull_i (line_pull_o),
  .reg_we_i    (reg_we_o),
  .addr_valid_i(addr_valid_i),
  .reg_addr_i  (reg_addr_o),
  .brk_i       (brk)
);

// File: tb/test_rto_target.sv
`timescale 1ns / 1ps
module test_rto_target;
  localparam int CPU = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_pull = 1'b0;
  logic dut_pull;
  logic line;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic we, avalid;
  logic [7:0] mem [128];
  int cyc = 0, n_chk = 0, n_err = 0, t_rise = 0;
  bit reply_win = 1'b0;
  int q_wr[$];

  always #2.5 clk = ~clk;

  assign line   = ~(host_pull | dut_pull);
  assign rdata  = mem[addr];
  assign avalid = addr < 7'h40;

  rto_target #(.CYC_PER_US(CPU)) i_rto_target (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_i      (line),
    .line_pull_o (dut_pull),
    .reg_addr_o  (addr),
    .reg_wdata_o (wdata),
    .reg_we_o    (we),
    .reg_rdata_i (rdata),
    .addr_valid_i(avalid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // per-clock model comparison: pull only inside an expected reply window
  always @(negedge clk) if (rst_n) begin
    if (we) begin
      q_wr.push_back({16'h0, 1'b0, addr, wdata});
      if (avalid) mem[addr] = wdata;
    end
    n_chk++;
    if (dut_pull && !reply_win) begin
      n_err++;
      $display("FAIL R8 pull outside reply at cycle %0d: actual=1 expected=0", cyc);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_bit(bit b, bit tail);
    host_pull = 1'b1;
    tick((b ? 15 : 110) * CPU);
    host_pull = 1'b0;
    t_rise = cyc;
    if (tail) tick((b ? 185 : 90) * CPU);
  endtask

  task automatic send_byte(logic [7:0] v, bit tail_last);
    for (int i = 0; i < 8; i++) send_bit(v[i], (i < 7) || tail_last);
  endtask

  task automatic send_break();
    host_pull = 1'b1;
    tick(200 * CPU);
    host_pull = 1'b0;
    tick(50 * CPU);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    int n, t0, tprev, w;
    v = '0;
    tprev = 0;
    reply_win = 1'b1;
    for (int i = 0; i < 8; i++) begin
      n = 0;
      while (!dut_pull && n < 400 * CPU) begin tick(1); n++; end
      if (!dut_pull) begin
        chk(1'b0, "R5", "reply start missing", 0, 1);
        break;
      end
      t0 = cyc;
      if (i == 0)
        chk(t0 - t_rise >= 190 * CPU && t0 - t_rise <= 320 * CPU, "R5", "turnaround cycles",
            t0 - t_rise, 255 * CPU);
      else
        chk(t0 - tprev >= 190 * CPU && t0 - tprev <= 250 * CPU, "R6", "bit period cycles",
            t0 - tprev, 210 * CPU);
      n = 0;
      while (dut_pull && n < 300 * CPU) begin tick(1); n++; end
      w = cyc - t0;
      chk(w >= 32 * CPU, "R6", "start low cycles", w, 40 * CPU);
      v[i] = (w < 80 * CPU);
      tprev = t0;
    end
    tick(250 * CPU);
    reply_win = 1'b0;
  endtask

  task automatic do_write(logic [6:0] a, logic [7:0] d, bit expect_we);
    q_wr.delete();
    send_byte({1'b1, a}, 1'b1);
    send_byte(d, 1'b1);
    chk(q_wr.size() == (expect_we ? 1 : 0), expect_we ? "R2" : "R3", "write strobes",
        q_wr.size(), expect_we ? 1 : 0);
    if (expect_we && q_wr.size() == 1)
      chk(q_wr[0] == {1'b0, a, d}, "R2", "write addr/data", q_wr[0], {1'b0, a, d});
  endtask

  task automatic do_read(logic [6:0] a, logic [7:0] exp, string req);
    logic [7:0] v;
    q_wr.delete();
    send_byte({1'b0, a}, 1'b0);
    recv_byte(v);
    chk(v == exp, req, "read value", v, exp);
    chk(q_wr.size() == 0, "R4", "no strobe on read", q_wr.size(), 0);
    tick(20 * CPU);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R1: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    logic [7:0] init50, init06;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
    init50 = mem[7'h50];
    tick(4);
    chk(dut_pull == 1'b0, "R8", "reset pull", int'(dut_pull), 0);
    chk(we == 1'b0, "R8", "reset strobe", int'(we), 0);
    rst_n = 1'b1;
    tick(60 * CPU);

    do_write(7'h05, 8'hA5, 1'b1);          // R1 R2
    do_write(7'h12, 8'h3C, 1'b1);          // R2
    do_read(7'h05, 8'hA5, "R4");           // R1 R4 R5 R6
    do_read(7'h12, 8'h3C, "R4");
    do_write(7'h20, 8'hFF, 1'b1);
    do_read(7'h20, 8'hFF, "R6");           // all ones encoding
    do_write(7'h21, 8'h00, 1'b1);
    do_read(7'h21, 8'h00, "R6");           // all zeros encoding
    do_write(7'h50, 8'h77, 1'b0);          // R3 invalid address
    do_read(7'h50, init50, "R3");

    // R7: break inside a command byte
    q_wr.delete();
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
    send_break();
    do_write(7'h07, 8'h81, 1'b1);
    do_read(7'h07, 8'h81, "R7");

    // R7: break inside a data byte
    init06 = mem[7'h06];
    q_wr.delete();
    send_byte({1'b1, 7'h06}, 1'b1);
    for (int i = 0; i < 4; i++) send_bit(i[0], 1'b1);
    send_break();
    chk(q_wr.size() == 0, "R7", "strobe after aborted data", q_wr.size(), 0);
    do_read(7'h06, init06, "R7");

    finish_run();
  end
endmodule